// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Code Encoder

This block sits behind the comparator bank of a flash analog-to-digital converter. It turns a 63-bit thermometer word into a 6-bit output code, and it takes one thermometer word per clock.

To find where the run of ones ends, it uses one row detector per comparator position. Each detector is a three-input gate: it needs the bit below to read one, its own bit to read one, and the bit above to read zero. A stray one that stands alone in the zero region therefore selects no row.

The selected row reads a word from a computed table. The table holds either the plain binary row index or its Gray code, chosen per sample. If an error pattern still selects more than one row, the selected words are ORed together and a status flag is raised.

The block has one register stage. Code, flag and valid appear on the clock edge after the input is presented with its valid bit.

Top module: `thermo_rom_encoder`

## Requirements
- R1: The bit `thermIn[i]` is the output of comparator i+1. In binary mode (`grayMode`=0), an input whose lowest k bits are one and whose other bits are zero (k from 0 to 63) gives `codeOut`=k and `multiHit`=0. These appear one clock after the input is sampled with `inValid`=1.
- R2: In Gray mode (`grayMode`=1), the same clean input with k ones gives `codeOut` = k XOR (k>>1), with `multiHit`=0.
- R3: Position 0 below the vector counts as one and position 64 above it counts as zero. An all-zero input selects no row and gives code 0. An all-ones input selects row 63 and gives code 63 in binary mode and 32 in Gray mode.
- R4: Take a clean input with k ones. Add a single extra one at comparator p, where p ≥ k+2, so that comparator p-1 reads zero. The output is still k (or its Gray code), with `multiHit`=0.
- R5: Take a clean input with k ones, k ≥ 4. Clear comparator h, with 2 ≤ h ≤ k-2. Rows h-1 and k are both selected. The output is the OR of the words for h-1 and for k in the current mode, and `multiHit`=1.
- R6: `outValid` equals `inValid` delayed by one clock. When `inValid`=0, `codeOut` and `multiHit` keep their previous values.
- R7: A synchronous active-high `rst` clears `codeOut`, `multiHit` and `outValid` to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thermIn | input | 63 | Comparator outputs, bit i = comparator i+1 |
| inValid | input | 1 | Sample `thermIn` this cycle |
| grayMode | input | 1 | 1 = Gray-coded table words, 0 = binary |
| codeOut | output | 6 | Registered output code |
| outValid | output | 1 | `inValid` delayed one clock |
| multiHit | output | 1 | More than one row was selected for this code |

## Verification
The bench sweeps every clean thermometer level in both modes, and the two ends catch a design that pads the edges of the vector wrongly. For example, such a design would give all-ones as 62 or all-zeros as a nonzero code. Every isolated stray one above the transition is tried. A design that kept a two-input detector would select the stray row, and its output would jump toward that position with the flag raised. Every single hole below the transition is also tried. A design that picked one row by priority instead of ORing the words would miss the OR value, and one without the flag would leave `multiHit` low. Idle cycles with a changed input check that the output holds and does not follow the input.

// File: rtl/thermo_enc_pkg.sv
package thermo_enc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadCode;   // capture a new code this edge
    logic useGray;    // table words in Gray form
    logic clearAll;   // synchronous clear
  } encStrobe_t;
endpackage

// File: rtl/thermo_enc_ctrl.sv
module thermo_enc_ctrl
  import thermo_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       grayMode,
  output encStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.loadCode = inValid & ~rst;
    strobe.useGray  = grayMode;
    strobe.clearAll = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R6: valid follows input valid one cycle later
  a_r6_valid_rise: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r6_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R7: reset clears valid
  a_r7_reset_valid: assert property (@(posedge clk) rst |=> !outValid);
endmodule

// File: rtl/thermo_enc_datapath.sv
module thermo_enc_datapath
  import thermo_enc_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int LEVELS = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  encStrobe_t        strobe,
  input  logic [LEVELS-1:0] thermIn,
  output logic [CODE_W-1:0] codeOut,
  output logic              multiHit
);
  // extended[m] is comparator m; fixed one below, fixed zero above
  logic [LEVELS+1:0] extended;
  logic [LEVELS:1]   rowSel;
  logic [CODE_W-1:0] codeNext;
  logic              multiNext;

  assign extended = {1'b0, thermIn, 1'b1};

  // Three-input row detectors
  for (genvar m = 1; m <= LEVELS; m++) begin : g_row
    assign rowSel[m] = extended[m-1] & extended[m] & ~extended[m+1];
  end

  function automatic logic [CODE_W-1:0] tableWord(input int idx, input logic gray);
    logic [CODE_W-1:0] b;
    b = CODE_W'(idx);
    return gray ? (b ^ (b >> 1)) : b;
  endfunction

  // OR of the selected words, plus detection of a second hit
  always_comb begin
    logic anyHit;
    anyHit    = 1'b0;
    multiNext = 1'b0;
    codeNext  = '0;
    for (int m = 1; m <= LEVELS; m++) begin
      if (rowSel[m]) begin
        codeNext = codeNext | tableWord(m, strobe.useGray);
        if (anyHit) multiNext = 1'b1;
        anyHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      codeOut  <= '0;
      multiHit <= 1'b0;
    end else if (strobe.loadCode) begin
      codeOut  <= codeNext;
      multiHit <= multiNext;
    end
  end

  // R3: no row selected gives code zero
  a_r3_empty_zero: assert property (@(posedge clk) disable iff (strobe.clearAll)
    strobe.loadCode && (rowSel == '0) |=> (codeOut == '0) && !multiHit);
  // R5: several rows raise the flag
  a_r5_multi_flag: assert property (@(posedge clk) disable iff (strobe.clearAll)
    strobe.loadCode && !$onehot0(rowSel) |=> multiHit);
  // R4: a single row leaves the flag low
  a_r4_single_clear: assert property (@(posedge clk) disable iff (strobe.clearAll)
    strobe.loadCode && $onehot0(rowSel) |=> !multiHit);
  // R6: hold while idle
  a_r6_hold: assert property (@(posedge clk) disable iff (strobe.clearAll)
    !strobe.loadCode |=> $stable(codeOut) && $stable(multiHit));
  // R7: reset clears code and flag
  a_r7_reset_code: assert property (@(posedge clk)
    strobe.clearAll |=> (codeOut == '0) && !multiHit);
endmodule

// File: rtl/thermo_rom_encoder.sv
module thermo_rom_encoder #(
  parameter int CODE_W = 6,
  localparam int LEVELS = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] thermIn,
  input  logic              inValid,
  input  logic              grayMode,
  output logic [CODE_W-1:0] codeOut,
  output logic              outValid,
  output logic              multiHit
);
  thermo_enc_pkg::encStrobe_t strobe;

  thermo_enc_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .grayMode (grayMode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  thermo_enc_datapath #(.CODE_W(CODE_W), .LEVELS(LEVELS)) dp_i (
    .clk      (clk),
    .strobe   (strobe),
    .thermIn  (thermIn),
    .codeOut  (codeOut),
    .multiHit (multiHit)
  );
endmodule

// File: tb/thermo_rom_encoder_tb_top.sv
module thermo_rom_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [62:0] thermIn;
  logic        inValid;
  logic        grayMode;
  logic [5:0]  codeOut;
  logic        outValid;
  logic        multiHit;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  thermo_rom_encoder dut_i (
    .clk(clk), .rst(rst), .thermIn(thermIn), .inValid(inValid),
    .grayMode(grayMode), .codeOut(codeOut), .outValid(outValid),
    .multiHit(multiHit)
  );

  function automatic logic [62:0] onesVec(input int k);
    logic [63:0] v;
    v = (64'd1 << k) - 64'd1;
    return v[62:0];
  endfunction

  function automatic logic [5:0] word(input int v, input logic g);
    logic [5:0] b;
    b = 6'(v);
    return g ? (b ^ (b >> 1)) : b;
  endfunction

  task automatic check(input string req, input logic [5:0] expCode,
                       input logic expMulti, input logic expValid);
    total++;
    if (codeOut !== expCode || multiHit !== expMulti || outValid !== expValid) begin
      bad++;
      $display("FAIL %s: code=%0d multi=%0b valid=%0b expected code=%0d multi=%0b valid=%0b",
               req, codeOut, multiHit, outValid, expCode, expMulti, expValid);
    end
  endtask

  // drive at negedge, result appears after next posedge, sample at following negedge
  task automatic apply(input logic [62:0] v, input logic g);
    thermIn  = v;
    grayMode = g;
    inValid  = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; thermIn = '1; inValid = 1'b1; grayMode = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R7 reset", 6'd0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1 / R2: every clean level in both modes; R3 ends included
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k <= 63; k++) begin
        apply(onesVec(k), g[0]);
        if (k == 0 || k == 63) check("R3 boundary", word(k, g[0]), 1'b0, 1'b1);
        else if (g == 0) check("R1 clean binary", word(k, 1'b0), 1'b0, 1'b1);
        else check("R2 clean gray", word(k, 1'b1), 1'b0, 1'b1);
      end
    end

    // R4: isolated stray one at comparator p, p >= k+2
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k <= 61; k++) begin
        for (int p = k + 2; p <= 63; p++) begin
          apply(onesVec(k) | (63'd1 << (p - 1)), g[0]);
          check("R4 stray one", word(k, g[0]), 1'b0, 1'b1);
        end
      end
    end

    // R5: single hole at comparator h, 2 <= h <= k-2
    for (int g = 0; g < 2; g++) begin
      for (int k = 4; k <= 63; k++) begin
        for (int h = 2; h <= k - 2; h++) begin
          apply(onesVec(k) & ~(63'd1 << (h - 1)), g[0]);
          check("R5 hole", word(k, g[0]) | word(h - 1, g[0]), 1'b1, 1'b1);
        end
      end
    end

    // R6: hold while idle; load a hole pattern (flag high) then idle with new input
    apply(onesVec(40) & ~(63'd1 << 9), 1'b0);
    check("R6 load before idle", 6'd40 | 6'd9, 1'b1, 1'b1);
    thermIn = onesVec(5); inValid = 1'b0;
    @(negedge clk);
    check("R6 idle hold", 6'd40 | 6'd9, 1'b1, 1'b0);
    @(negedge clk);
    check("R6 idle hold second", 6'd40 | 6'd9, 1'b1, 1'b0);
    apply(onesVec(5), 1'b0);
    check("R6 resume", 6'd5, 1'b0, 1'b1);

    // R7: reset mid-stream
    apply(onesVec(33), 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset mid-stream", 6'd0, 1'b0, 1'b0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule